// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns a fixed-point angle in radians into its sine and cosine. It has a rotation-mode CORDIC engine that is fully unrolled: every micro-rotation sits in its own pipeline stage, so the block takes a new angle on every clock and returns results in the same order. The starting vector is pre-scaled by the inverse of the CORDIC gain (about 1/1.6467602). Because of that, the outputs come out at unit scale, and no multiplier is needed after the engine.

A parameter selects one of two angle formats. The signed format covers the whole circle, [-π, +π]. Angles beyond ±π/2 are folded back by π before the iterations start, and both results are negated at the end. The unsigned format covers only the first quadrant, [0, +π/2], and its outputs are unsigned. All port widths follow from the chosen input and output fraction widths. A second parameter turns on a clock-enable input that stalls the whole pipeline.

Internally the engine runs FRAC_OUT+4 micro-rotations. It keeps 3+clog2(iterations) guard bits below the output LSB. It then rounds to nearest and clamps the result to the legal output range.

Top module: `cordic_sincos`

## Requirements
- R1: A clock edge with rst_n low clears valid_o, sin_o and cos_o to zero and empties the pipeline, so no sample that was in flight appears afterwards.
- R2: A sample accepted (valid_i high on an enabled edge) appears at valid_o exactly FRAC_OUT+6 enabled edges later (18 with defaults), and no valid_o appears without such a sample.
- R3: In signed mode the angle is a two's-complement code of FRAC_IN+3 bits with value code/2^FRAC_IN rad over [-π, +π]. sin_o and cos_o are signed, FRAC_OUT+2 bits wide, with value code/2^FRAC_OUT.
- R4: In unsigned mode the angle is an unsigned FRAC_IN+1 bit code (value code/2^FRAC_IN rad) over [0, +π/2]. The outputs are unsigned, FRAC_OUT+1 bits wide, with value code/2^FRAC_OUT.
- R5: Every result is faithfully rounded, meaning it lies less than one output LSB from the exact sine or cosine. This holds over the whole angle range, including angles in the second and third quadrants.
- R6: No output code exceeds 2^FRAC_OUT (the value 1.0) in magnitude.
- R7: With USE_ENABLE=1, an edge with en low changes no pipeline state. The outputs hold, valid_i and angle_i are ignored, and samples already in flight resume when en returns high.
- R8: With USE_ENABLE=0, the en input has no effect.
- R9: Back-to-back samples on consecutive edges each produce a result on consecutive edges, in input order.
- R10: An angle of zero gives cos code exactly 2^FRAC_OUT and sin code exactly 0, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all pipeline registers |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Pipeline enable, honoured only when USE_ENABLE=1 |
| valid_i | input | 1 | Marks angle_i as a sample to convert |
| angle_i | input | FRAC_IN+3 (signed mode) or FRAC_IN+1 | Angle in radians, fixed point |
| valid_o | output | 1 | Marks sin_o/cos_o as a result |
| sin_o | output | FRAC_OUT+2 (signed mode) or FRAC_OUT+1 | Sine of the angle |
| cos_o | output | FRAC_OUT+2 (signed mode) or FRAC_OUT+1 | Cosine of the angle |

## Verification
Four properties are checked on every cycle:
- A shadow shift register of accepted valids keeps the output strobe in step with the input.
- A frozen edge leaves every output unchanged.
- Every result respects the unit bound.
- sin²+cos² stays within the error that faithful rounding allows.

The accuracy of each individual value needs the bench scenarios, which compare against real-valued sine and cosine. So do the correct sign after quadrant folding, the exact endpoint codes, the result order and the flushing of in-flight samples by reset.

// File: rtl/cordic_sc_pkg.sv
`timescale 1ns/1ps
// Package cordic_sc_pkg
// Elaboration-time arithmetic shared by the sine/cosine engine: the
// arctangent constants of the micro-rotations, the inverse CORDIC gain
// and conversion of reals to fixed point. Used only for constants.
package cordic_sc_pkg;

    localparam real PI_R = 3.14159265358979324;

    // 2^-n as a real
    function automatic real p2_neg(input int n);
        real r = 1.0;
        for (int k = 0; k < n; k++) r = r / 2.0;
        return r;
    endfunction

    // 2^n as a real
    function automatic real p2_pos(input int n);
        real r = 1.0;
        for (int k = 0; k < n; k++) r = r * 2.0;
        return r;
    endfunction

    // atan(2^-i) by its power series (t <= 0.5 for i >= 1)
    function automatic real atan_step(input int i);
        real t;
        real term;
        real acc;
        if (i == 0) return PI_R / 4.0;
        t    = p2_neg(i);
        acc  = 0.0;
        term = t;
        for (int k = 0; k < 40; k++) begin
            acc  = acc + (((k % 2) == 0) ? term : -term) / real'(2 * k + 1);
            term = term * t * t;
        end
        return acc;
    endfunction

    // square root by Newton iteration
    function automatic real root_r(input real v);
        real g = 1.0;
        for (int k = 0; k < 40; k++) g = 0.5 * (g + v / g);
        return g;
    endfunction

    // 1/K for n micro-rotations
    function automatic real gain_inv(input int n);
        real p = 1.0;
        for (int i = 0; i < n; i++) p = p / root_r(1.0 + p2_neg(2 * i));
        return p;
    endfunction

    // real to fixed point with frac fraction bits, rounded to nearest
    function automatic longint fix_of(input real v, input int frac);
        return longint'(v * p2_pos(frac));
    endfunction

endpackage

// File: rtl/sc_fold_stage.sv
`timescale 1ns/1ps
// Module sc_fold_stage
// Input register of the engine. It widens the angle to the internal
// fraction, and in signed mode folds angles beyond +-pi/2 by pi and
// flags the result for negation. It also loads the start vector (1/K, 0).
// Assumes the angle lies inside the documented range of its mode.
module sc_fold_stage #(
    parameter int SIGNED_ANGLE = 1,
    parameter int FRAC_IN      = 12,
    parameter int AW           = 15,
    parameter int FZ           = 19,
    parameter int ZW           = 22,
    parameter int FI           = 19,
    parameter int XW           = 22,
    parameter int NITER        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 valid_i,
    input  logic [AW-1:0]        angle_i,
    output logic                 v_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o,
    output logic                 flip_o
);
    localparam int SH = FZ - FRAC_IN;
    localparam logic signed [ZW-1:0] PI_C  =
        ZW'(cordic_sc_pkg::fix_of(cordic_sc_pkg::PI_R, FZ));
    localparam logic signed [ZW-1:0] HPI_C =
        ZW'(cordic_sc_pkg::fix_of(cordic_sc_pkg::PI_R / 2.0, FZ));
    localparam logic signed [XW-1:0] KINV_C =
        XW'(cordic_sc_pkg::fix_of(cordic_sc_pkg::gain_inv(NITER), FI));

    logic signed [ZW-1:0] a_w;
    logic signed [ZW-1:0] z_n;
    logic                 flip_n;

    generate
        if (SIGNED_ANGLE != 0) begin : g_full
            logic signed [AW-1:0] a_s;
            assign a_s = angle_i;
            // widen with sign, fold outer half-plane by pi
            always_comb begin
                a_w = ZW'(a_s) <<< SH;
                if (a_w > HPI_C) begin
                    z_n    = a_w - PI_C;
                    flip_n = 1'b1;
                end else if (a_w < -HPI_C) begin
                    z_n    = a_w + PI_C;
                    flip_n = 1'b1;
                end else begin
                    z_n    = a_w;
                    flip_n = 1'b0;
                end
            end
        end else begin : g_quad
            logic [ZW-1:0] a_z;
            // widen with zeros, first quadrant needs no folding
            always_comb begin
                a_z    = {{(ZW-AW){1'b0}}, angle_i};
                a_w    = $signed(a_z) <<< SH;
                z_n    = a_w;
                flip_n = 1'b0;
            end
        end
    endgenerate

    // capture folded angle together with the pre-scaled start vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            x_o    <= '0;
            y_o    <= '0;
            z_o    <= '0;
            flip_o <= 1'b0;
        end else if (ce) begin
            v_o    <= valid_i;
            x_o    <= KINV_C;
            y_o    <= '0;
            z_o    <= z_n;
            flip_o <= flip_n;
        end
    end
endmodule

// File: rtl/sc_micro_rot.sv
`timescale 1ns/1ps
// Module sc_micro_rot
// One registered micro-rotation of index IDX: it turns (x, y) by
// +-atan(2^-IDX) toward a zero residual angle. The shifts are
// arithmetic; the constant is rounded to FZ fraction bits.
module sc_micro_rot #(
    parameter int IDX = 0,
    parameter int XW  = 22,
    parameter int ZW  = 22,
    parameter int FZ  = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 v_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic                 flip_i,
    output logic                 v_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o,
    output logic                 flip_o
);
    localparam logic signed [ZW-1:0] ANG_C =
        ZW'(cordic_sc_pkg::fix_of(cordic_sc_pkg::atan_step(IDX), FZ));

    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;
    logic                 ccw;

    // scaled cross terms and rotation direction
    always_comb begin
        x_sh = x_i >>> IDX;
        y_sh = y_i >>> IDX;
        ccw  = ~z_i[ZW-1];
    end

    // apply the micro-rotation and carry the side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            x_o    <= '0;
            y_o    <= '0;
            z_o    <= '0;
            flip_o <= 1'b0;
        end else if (ce) begin
            v_o    <= v_i;
            flip_o <= flip_i;
            if (ccw) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - ANG_C;
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + ANG_C;
            end
        end
    end
endmodule

// File: rtl/sc_round_out.sv
`timescale 1ns/1ps
// Module sc_round_out
// Output register. It negates folded results, rounds from FI to
// FRAC_OUT fraction bits (nearest, ties up) and clamps to [-1, 1] in
// signed mode or [0, 1] in unsigned mode. Assumes FI > FRAC_OUT.
module sc_round_out #(
    parameter int SIGNED_ANGLE = 1,
    parameter int XW           = 22,
    parameter int FI           = 19,
    parameter int FRAC_OUT     = 12,
    parameter int OW           = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 v_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic                 flip_i,
    output logic                 valid_o,
    output logic [OW-1:0]        cos_o,
    output logic [OW-1:0]        sin_o
);
    localparam int SHR = FI - FRAC_OUT;
    localparam logic signed [XW-1:0] RND_C = XW'(longint'(1) << (SHR - 1));
    localparam logic signed [XW-1:0] ONE_C = XW'(longint'(1) << FRAC_OUT);
    localparam logic signed [XW-1:0] LOW_C = (SIGNED_ANGLE != 0) ? -ONE_C : '0;

    // negate, round and clamp one coordinate
    function automatic logic [OW-1:0] finish(input logic signed [XW-1:0] v,
                                             input logic neg);
        logic signed [XW-1:0] t;
        logic signed [XW-1:0] r;
        t = neg ? -v : v;
        r = (t + RND_C) >>> SHR;
        if (r > ONE_C)      r = ONE_C;
        else if (r < LOW_C) r = LOW_C;
        return OW'(r);
    endfunction

    // register the finished results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cos_o   <= '0;
            sin_o   <= '0;
        end else if (ce) begin
            valid_o <= v_i;
            cos_o   <= finish(x_i, flip_i);
            sin_o   <= finish(y_i, flip_i);
        end
    end
endmodule

// File: rtl/cordic_sincos.sv
`timescale 1ns/1ps
// Module cordic_sincos
// Fully unrolled rotation-mode CORDIC that gives sine and cosine of a
// fixed-point angle in radians. Pipeline: fold register, NITER
// micro-rotations, round register; latency NITER+2 enabled edges and
// one sample per edge. The angle must lie in its mode's range.
module cordic_sincos #(
    parameter int FRAC_IN      = 12,
    parameter int FRAC_OUT     = 12,
    parameter int SIGNED_ANGLE = 1,
    parameter int USE_ENABLE   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic valid_i,
    input  logic [(SIGNED_ANGLE != 0 ? FRAC_IN + 3 : FRAC_IN + 1) - 1:0] angle_i,
    output logic valid_o,
    output logic [(SIGNED_ANGLE != 0 ? FRAC_OUT + 2 : FRAC_OUT + 1) - 1:0] sin_o,
    output logic [(SIGNED_ANGLE != 0 ? FRAC_OUT + 2 : FRAC_OUT + 1) - 1:0] cos_o
);
    localparam int AW      = (SIGNED_ANGLE != 0) ? FRAC_IN + 3 : FRAC_IN + 1;
    localparam int OW      = (SIGNED_ANGLE != 0) ? FRAC_OUT + 2 : FRAC_OUT + 1;
    localparam int NITER   = FRAC_OUT + 4;
    localparam int GUARD   = 3 + $clog2(NITER);
    localparam int FI      = FRAC_OUT + GUARD;
    localparam int FZ      = (FI > FRAC_IN) ? FI : FRAC_IN;
    localparam int XW      = FI + 3;
    localparam int ZW      = FZ + 3;
    localparam int LATENCY = NITER + 2;

    logic ce;

    generate
        if (USE_ENABLE != 0) begin : g_en
            assign ce = en;
        end else begin : g_no_en
            logic unused_en;
            assign unused_en = en;
            assign ce        = 1'b1;
        end
    endgenerate

    logic                 vs   [0:NITER];
    logic                 fl   [0:NITER];
    logic signed [XW-1:0] xs   [0:NITER];
    logic signed [XW-1:0] ys   [0:NITER];
    logic signed [ZW-1:0] zs   [0:NITER];

    sc_fold_stage #(
        .SIGNED_ANGLE(SIGNED_ANGLE), .FRAC_IN(FRAC_IN), .AW(AW),
        .FZ(FZ), .ZW(ZW), .FI(FI), .XW(XW), .NITER(NITER)
    ) u_fold (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .valid_i(valid_i), .angle_i(angle_i),
        .v_o(vs[0]), .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0]), .flip_o(fl[0])
    );

    generate
        for (genvar i = 0; i < NITER; i++) begin : g_rot
            sc_micro_rot #(.IDX(i), .XW(XW), .ZW(ZW), .FZ(FZ)) u_rot (
                .clk(clk), .rst_n(rst_n), .ce(ce),
                .v_i(vs[i]), .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]), .flip_i(fl[i]),
                .v_o(vs[i+1]), .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1]),
                .flip_o(fl[i+1])
            );
        end
    endgenerate

    logic unused_resid;
    assign unused_resid = ^zs[NITER];

    sc_round_out #(
        .SIGNED_ANGLE(SIGNED_ANGLE), .XW(XW), .FI(FI),
        .FRAC_OUT(FRAC_OUT), .OW(OW)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .v_i(vs[NITER]), .x_i(xs[NITER]), .y_i(ys[NITER]), .flip_i(fl[NITER]),
        .valid_o(valid_o), .cos_o(cos_o), .sin_o(sin_o)
    );
endmodule

// File: rtl/cordic_sincos_chk.sv
`timescale 1ns/1ps
// Module cordic_sincos_chk
// Property checker bound into every cordic_sincos instance. It tracks
// accepted valids in a shadow shift register and checks the output
// strobe, the stall behaviour, the unit bound and sin^2+cos^2.
module cordic_sincos_chk #(
    parameter int FRAC_OUT     = 12,
    parameter int SIGNED_ANGLE = 1,
    parameter int USE_ENABLE   = 1,
    parameter int LATENCY      = 18,
    parameter int OW           = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          valid_i,
    input logic          valid_o,
    input logic [OW-1:0] sin_o,
    input logic [OW-1:0] cos_o
);
    localparam longint ONE_L  = longint'(1) << FRAC_OUT;
    localparam longint ONE2_L = longint'(1) << (2 * FRAC_OUT);
    localparam longint TOL_L  = 3 * ONE_L + 4;
    localparam longint LOW_L  = (SIGNED_ANGLE != 0) ? -ONE_L : 0;

    logic               ce_m;
    logic [LATENCY-1:0] vshadow;
    logic               rst_q;
    longint             s_v;
    longint             c_v;
    longint             err;

    assign ce_m = (USE_ENABLE != 0) ? en : 1'b1;

    // shadow of accepted valids, advanced on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n)    vshadow <= '0;
        else if (ce_m) vshadow <= {vshadow[LATENCY-2:0], valid_i};
    end

    // remember that the last edge was a reset edge
    always_ff @(posedge clk) rst_q <= ~rst_n;

    generate
        if (SIGNED_ANGLE != 0) begin : g_s
            assign s_v = longint'($signed(sin_o));
            assign c_v = longint'($signed(cos_o));
        end else begin : g_u
            assign s_v = longint'(sin_o);
            assign c_v = longint'(cos_o);
        end
    endgenerate

    // deviation of the squared magnitude from one
    always_comb err = s_v * s_v + c_v * c_v - ONE2_L;

    // R1: after a reset edge all outputs read zero
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (valid_o == 1'b0 && sin_o == '0 && cos_o == '0);
        end
    end

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == vshadow[LATENCY-1]);

    a_r5_unit_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (err <= TOL_L && err >= -TOL_L));

    a_r6_unit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (s_v <= ONE_L && s_v >= LOW_L && c_v <= ONE_L && c_v >= LOW_L));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_ENABLE != 0 && !en) |=> ($stable(sin_o) && $stable(cos_o) && $stable(valid_o)));
endmodule

bind cordic_sincos cordic_sincos_chk #(
    .FRAC_OUT(FRAC_OUT), .SIGNED_ANGLE(SIGNED_ANGLE), .USE_ENABLE(USE_ENABLE),
    .LATENCY(LATENCY), .OW(OW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .valid_i(valid_i),
    .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/sim_cordic_sincos.sv
`timescale 1ns/1ps
// Bench for cordic_sincos: u0 is signed with enable, u1 unsigned without.
module sim_cordic_sincos;
    localparam int  LAT  = 18;
    localparam real SCL  = 4096.0;
    localparam int  NVEC = 14;
    // stimulus rows: angle codes (rad * 4096); expected values are sin/cos
    localparam int VEC [NVEC] = '{0, 1000, -1000, 3217, 6433, -6433, 6500,
                                  -6500, 9000, -9000, 12867, -12867, 12000, -4000};
    localparam int UVEC [6] = '{0, 6433, 800, 2000, 4000, 6000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en0 = 1'b0, v0 = 1'b0, en1 = 1'b0, v1 = 1'b0;
    logic [14:0] a0 = '0;
    logic [12:0] a1 = '0;
    logic        vo0, vo1;
    logic [13:0] s0, c0;
    logic [12:0] s1, c1;
    logic [28:0] prev0 = '0;
    logic        en0_q = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0, ecyc = 0, got0 = 0;
    int q_ang[$], q_t[$], q1_ang[$], q1_t[$];

    always #2.5 clk = ~clk;

    cordic_sincos u0 (.clk(clk), .rst_n(rst_n), .en(en0), .valid_i(v0), .angle_i(a0),
                      .valid_o(vo0), .sin_o(s0), .cos_o(c0));
    cordic_sincos #(.SIGNED_ANGLE(0), .USE_ENABLE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en1), .valid_i(v1), .angle_i(a1),
        .valid_o(vo1), .sin_o(s1), .cos_o(c1));

    task automatic chk_eq(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int got, input real exp);
        real d = real'(got) - exp;
        n_chk++;
        if (d >= 1.0 || d <= -1.0) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %f", tag, got, exp);
        end
    endtask

    // edge counters; ecyc counts edges on which u0 is enabled
    always @(posedge clk) begin
        cyc++;
        en0_q = en0;
        if (en0) ecyc++;
        if (cyc > 4000) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    // u0 result monitor (R2, R3, R5, R6, R7, R9, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en0_q) begin
                chk_eq("R7 outputs held while stalled", int'({vo0, s0, c0}), int'(prev0));
            end else if (vo0) begin
                if (q_ang.size() == 0) begin
                    chk_eq("R2 stray valid_o", 1, 0);
                end else begin
                    int a;
                    int t;
                    int sv;
                    int cv;
                    a  = q_ang.pop_front();
                    t  = q_t.pop_front();
                    sv = $signed(s0);
                    cv = $signed(c0);
                    got0++;
                    chk_eq("R2 latency", ecyc - t, LAT);
                    chk_near("R5 sin", sv, $sin(real'(a) / SCL) * SCL);
                    chk_near("R5 cos", cv, $cos(real'(a) / SCL) * SCL);
                    chk_eq("R6 bound", int'(sv <= 4096 && sv >= -4096 && cv <= 4096 && cv >= -4096), 1);
                    if (a == 0) begin
                        chk_eq("R10 cos at zero", cv, 4096);
                        chk_eq("R10 sin at zero", sv, 0);
                    end
                end
            end
        end
        prev0 = {vo0, s0, c0};
    end

    // u1 result monitor (R4, R8, R10)
    always @(negedge clk) begin
        if (rst_n && vo1) begin
            if (q1_ang.size() == 0) begin
                chk_eq("R8 stray valid_o", 1, 0);
            end else begin
                int a;
                int t;
                a = q1_ang.pop_front();
                t = q1_t.pop_front();
                chk_eq("R8 latency with en ignored", cyc - t, LAT);
                chk_near("R4 sin", int'(s1), $sin(real'(a) / SCL) * SCL);
                chk_near("R4 cos", int'(c1), $cos(real'(a) / SCL) * SCL);
                if (a == 0) begin
                    chk_eq("R10 unsigned cos at zero", int'(c1), 4096);
                    chk_eq("R10 unsigned sin at zero", int'(s1), 0);
                end
            end
        end
    end

    task automatic drive0(input int ang, input logic e, input logic v);
        @(negedge clk);
        a0  = 15'(ang);
        en0 = e;
        v0  = v;
        if (v && e) begin
            q_ang.push_back(ang);
            q_t.push_back(ecyc);
        end
    endtask

    task automatic drive1(input int ang, input logic e, input logic v);
        @(negedge clk);
        a1  = 13'(ang);
        en1 = e;
        v1  = v;
        if (v) begin
            q1_ang.push_back(ang);
            q1_t.push_back(cyc);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_eq("R1 reset valid_o u0", int'(vo0), 0);
        chk_eq("R1 reset sin/cos u0", int'({s0, c0}), 0);
        chk_eq("R1 reset valid_o u1", int'(vo1), 0);
        chk_eq("R1 reset sin/cos u1", int'({s1, c1}), 0);
        rst_n = 1'b1;

        // R3, R5, R9: whole table back to back through the signed engine
        for (int k = 0; k < NVEC; k++) drive0(VEC[k], 1'b1, 1'b1);
        repeat (LAT + 4) drive0(0, 1'b1, 1'b0);
        chk_eq("R9 results returned back to back", got0, NVEC);
        chk_eq("R2 pending after drain", q_ang.size(), 0);

        // R7: stalls with junk valid samples while others are in flight
        drive0(2500, 1'b1, 1'b1);
        drive0(-7000, 1'b1, 1'b1);
        for (int k = 0; k < 5; k++) drive0(5000, 1'b0, 1'b1);
        drive0(11000, 1'b1, 1'b1);
        for (int k = 0; k < 12; k++) drive0(0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) drive0(-3000, 1'b0, 1'b1);
        repeat (LAT + 4) drive0(0, 1'b1, 1'b0);
        chk_eq("R7 pending after stalls", q_ang.size(), 0);

        // R4, R8, R10: unsigned engine with en toggling
        for (int k = 0; k < 6; k++) drive1(UVEC[k], 1'(k % 2), 1'b1);
        for (int k = 0; k < LAT + 4; k++) drive1(0, 1'(k % 2), 1'b0);
        chk_eq("R8 pending after drain", q1_ang.size(), 0);

        // R1: reset flushes samples in flight
        for (int k = 0; k < 5; k++) drive0(1500 * k, 1'b1, 1'b1);
        @(negedge clk);
        v0 = 1'b0;
        rst_n = 1'b0;
        q_ang.delete();
        q_t.delete();
        @(negedge clk);
        chk_eq("R1 mid-run reset valid_o", int'(vo0), 0);
        chk_eq("R1 mid-run reset sin/cos", int'({s0, c0}), 0);
        rst_n = 1'b1;
        repeat (LAT + 4) drive0(0, 1'b1, 1'b0);
        chk_eq("R1 no stray after reset", got0, NVEC + 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule